// File: doc/BRIEF.md
# Half-Precision Sign-Inject, Min/Max and Compare Unit

This unit evaluates the non-rounding two-operand operations on 16-bit binary floating-point values: sign injection in three variants, minimum, maximum, and the three ordered comparisons equal, less-than and less-or-equal. A 3-bit operation code selects the function. Float-valued operations return a 16-bit result. Comparisons return a single truth bit, zero-extended to the integer register width. A 5-bit exception vector is produced alongside, and the only bit it can ever set is the invalid-operation bit.

NaN inputs and signed zeros follow the IEEE rules. Minimum and maximum pass the non-NaN operand through, and return the canonical NaN when both inputs are NaN. Equality, minimum and maximum are quiet operations. The two ordered relations are signalling operations. By default the results are captured in one output register stage. A parameter can remove that stage and leave the unit purely combinational.

Top module: `hcmp_unit`

## Requirements
- R1: Operation codes 0, 1 and 2 return operand A's exponent and mantissa (bits 14:0). The sign bit 15 is taken from B's sign for code 0, from the inverse of B's sign for code 1, and from the XOR of both signs for code 2. These operations raise no flag, even when an input is a NaN.
- R2: When both operands are positive, less-or-equal orders them by exponent first and then by mantissa. When both are negative, the magnitude order is reversed.
- R3: With a negative A and a positive B, less-or-equal is true. With a positive A and a negative B, it is true only when both are zeros. Equality treats +0 and -0 as equal, and less-than between them is false.
- R4: For minimum (code 3) and maximum (code 4), two NaN inputs give the canonical NaN 0x7E00. A single NaN input gives the other operand.
- R5: Minimum returns -0 when its operands are -0 and +0, in either order. Maximum returns +0 for the same operands.
- R6: Equality (code 5), minimum and maximum set the invalid bit only when at least one input is a signalling NaN. A signalling NaN has an all-ones exponent, mantissa bit 9 clear, and a non-zero mantissa.
- R7: Less-than (code 6) and less-or-equal (code 7) set the invalid bit when either input is any NaN, quiet or signalling.
- R8: Any comparison with a NaN input returns false.
- R9: The flag vector has the invalid bit at bit 4, and bits 3:0 are always 0. The compare output holds its truth value in bit 0, and every bit above bit 0 is 0. The compare output is all zero for codes 0 to 4, and the float output is all zero for codes 5 to 7.
- R10: With the output stage present, the outputs show the result for the inputs present at the previous rising clock edge. While reset is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| op_i | input | 3 | Operation code (0 to 7) |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| fp_res_o | output | 16 | Float result of sign-inject, min and max |
| cmp_res_o | output | 32 | Zero-extended comparison result |
| flags_o | output | 5 | Exception flags, invalid at bit 4 |

## Verification
The only state in this unit is its output register, so an internal fault cannot hide: a wrong classification, a wrong ordering or a wrong select shows on the outputs in the cycle right after the inputs that trigger it. The vectors pair each ordering rule with its mirror image: swapped operands, mixed signs, both zero signs, quiet and signalling NaNs. This means a swapped comparison, an inverted magnitude test or a misplaced flag gives a visibly wrong bit after exactly one clock. Reset and latency are checked directly at the ports, around the clock edge.

// File: rtl/hcmp_pkg.sv
`timescale 1ns/1ps
package hcmp_pkg;

   typedef enum logic [2:0] {
      OP_SGNJ  = 3'd0,
      OP_SGNJN = 3'd1,
      OP_SGNJX = 3'd2,
      OP_MIN   = 3'd3,
      OP_MAX   = 3'd4,
      OP_EQ    = 3'd5,
      OP_LT    = 3'd6,
      OP_LE    = 3'd7
   } hcmp_op_e;

   // Per-operand classification shared by ordering and selection logic
   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_nan;
      logic is_snan;
   } hcmp_cls_t;

endpackage

// File: rtl/hcmp_classify.sv
`timescale 1ns/1ps
module hcmp_classify
   import hcmp_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 10,
   parameter int FLEN  = 1 + EXP_W + MAN_W
) (
   input  logic [FLEN-1:0] val_i,
   output hcmp_cls_t       cls_o
);

   localparam int SIGN_POS = FLEN - 1;
   localparam int QBIT_POS = MAN_W - 1;

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_ones;
   logic             exp_zero;
   logic             man_zero;

   assign exp_f    = val_i[SIGN_POS-1:MAN_W];
   assign man_f    = val_i[MAN_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_zero = ~|exp_f;
   assign man_zero = ~|man_f;

   always_comb begin
      cls_o.sign    = val_i[SIGN_POS];
      cls_o.is_zero = exp_zero & man_zero;
      cls_o.is_nan  = exp_ones & ~man_zero;
      cls_o.is_snan = exp_ones & ~man_zero & ~man_f[QBIT_POS];
   end

endmodule

// File: rtl/hcmp_order.sv
`timescale 1ns/1ps
module hcmp_order
   import hcmp_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 10,
   parameter int FLEN  = 1 + EXP_W + MAN_W
) (
   input  logic [FLEN-1:0] a_i,
   input  logic [FLEN-1:0] b_i,
   input  hcmp_cls_t       cls_a_i,
   input  hcmp_cls_t       cls_b_i,
   output logic            le_ab_o,
   output logic            le_ba_o,
   output logic            eq_o
);

   localparam int MAG_W = FLEN - 1;

   // Ordering of two non-NaN values; NaN screening is done by the selector
   function automatic logic le_fn(
      input logic [MAG_W-1:0] mag_x,
      input logic             sgn_x,
      input logic             zero_x,
      input logic [MAG_W-1:0] mag_y,
      input logic             sgn_y,
      input logic             zero_y
   );
      logic res;
      unique case ({sgn_x, sgn_y})
         2'b00:   res = (mag_x <= mag_y);
         2'b11:   res = (mag_x >= mag_y);
         2'b10:   res = 1'b1;
         default: res = zero_x & zero_y;
      endcase
      return res;
   endfunction

   logic [MAG_W-1:0] mag_a;
   logic [MAG_W-1:0] mag_b;

   assign mag_a = a_i[MAG_W-1:0];
   assign mag_b = b_i[MAG_W-1:0];

   assign le_ab_o = le_fn(mag_a, cls_a_i.sign, cls_a_i.is_zero,
                          mag_b, cls_b_i.sign, cls_b_i.is_zero);
   assign le_ba_o = le_fn(mag_b, cls_b_i.sign, cls_b_i.is_zero,
                          mag_a, cls_a_i.sign, cls_a_i.is_zero);
   assign eq_o    = (cls_a_i.is_zero & cls_b_i.is_zero) | (a_i == b_i);

endmodule

// File: rtl/hcmp_result.sv
`timescale 1ns/1ps
module hcmp_result
   import hcmp_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 10,
   parameter int FLEN  = 1 + EXP_W + MAN_W
) (
   input  hcmp_op_e        op_i,
   input  logic [FLEN-1:0] a_i,
   input  logic [FLEN-1:0] b_i,
   input  hcmp_cls_t       cls_a_i,
   input  hcmp_cls_t       cls_b_i,
   input  logic            le_ab_i,
   input  logic            le_ba_i,
   input  logic            eq_i,
   output logic [FLEN-1:0] fp_o,
   output logic            cmp_o,
   output logic            nv_o
);

   localparam int MAG_W = FLEN - 1;
   localparam logic [FLEN-1:0] CANON_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic            any_nan;
   logic            both_nan;
   logic            any_snan;
   logic            both_zero;
   logic [MAG_W-1:0] a_mag;
   logic [FLEN-1:0] min_val;
   logic [FLEN-1:0] max_val;

   assign any_nan   = cls_a_i.is_nan | cls_b_i.is_nan;
   assign both_nan  = cls_a_i.is_nan & cls_b_i.is_nan;
   assign any_snan  = cls_a_i.is_snan | cls_b_i.is_snan;
   assign both_zero = cls_a_i.is_zero & cls_b_i.is_zero;
   assign a_mag     = a_i[MAG_W-1:0];

   always_comb begin
      if (both_nan)            min_val = CANON_NAN;
      else if (cls_a_i.is_nan) min_val = b_i;
      else if (cls_b_i.is_nan) min_val = a_i;
      else if (both_zero)      min_val = cls_a_i.sign ? a_i : b_i;
      else                     min_val = le_ab_i ? a_i : b_i;
   end

   always_comb begin
      if (both_nan)            max_val = CANON_NAN;
      else if (cls_a_i.is_nan) max_val = b_i;
      else if (cls_b_i.is_nan) max_val = a_i;
      else if (both_zero)      max_val = cls_a_i.sign ? b_i : a_i;
      else                     max_val = le_ba_i ? a_i : b_i;
   end

   always_comb begin
      fp_o  = '0;
      cmp_o = 1'b0;
      nv_o  = 1'b0;
      unique case (op_i)
         OP_SGNJ:  fp_o = {cls_b_i.sign, a_mag};
         OP_SGNJN: fp_o = {~cls_b_i.sign, a_mag};
         OP_SGNJX: fp_o = {cls_a_i.sign ^ cls_b_i.sign, a_mag};
         OP_MIN: begin
            fp_o = min_val;
            nv_o = any_snan;
         end
         OP_MAX: begin
            fp_o = max_val;
            nv_o = any_snan;
         end
         OP_EQ: begin
            cmp_o = ~any_nan & eq_i;
            nv_o  = any_snan;
         end
         OP_LT: begin
            cmp_o = ~any_nan & le_ab_i & ~eq_i;
            nv_o  = any_nan;
         end
         OP_LE: begin
            cmp_o = ~any_nan & le_ab_i;
            nv_o  = any_nan;
         end
         default: begin
            fp_o  = '0;
            cmp_o = 1'b0;
            nv_o  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/hcmp_unit.sv
`timescale 1ns/1ps
module hcmp_unit
   import hcmp_pkg::*;
#(
   parameter int EXP_W     = 5,
   parameter int MAN_W     = 10,
   parameter int XLEN      = 32,
   parameter int FLAG_W    = 5,
   parameter int NV_POS    = 4,
   parameter int OUT_STAGE = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2:0]               op_i,
   input  logic [EXP_W+MAN_W:0]     opa_i,
   input  logic [EXP_W+MAN_W:0]     opb_i,
   output logic [EXP_W+MAN_W:0]     fp_res_o,
   output logic [XLEN-1:0]          cmp_res_o,
   output logic [FLAG_W-1:0]        flags_o
);

   localparam int FLEN     = 1 + EXP_W + MAN_W;
   localparam int NUM_OPND = 2;

   // Elaboration-time parameter checks
   if (EXP_W < 2) begin : g_bad_exp
      $error("hcmp_unit: EXP_W must be at least 2");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("hcmp_unit: MAN_W must be at least 2");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("hcmp_unit: XLEN must be at least 1");
   end
   if (NV_POS >= FLAG_W || NV_POS < 0) begin : g_bad_nv
      $error("hcmp_unit: NV_POS outside the flag vector");
   end
   if (OUT_STAGE != 0 && OUT_STAGE != 1) begin : g_bad_stage
      $error("hcmp_unit: OUT_STAGE must be 0 or 1");
   end

   hcmp_op_e        op_sel;
   logic [FLEN-1:0] opnd [NUM_OPND];
   hcmp_cls_t       cls  [NUM_OPND];

   assign op_sel  = hcmp_op_e'(op_i);
   assign opnd[0] = opa_i;
   assign opnd[1] = opb_i;

   for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_cls
      hcmp_classify #(
         .EXP_W (EXP_W),
         .MAN_W (MAN_W),
         .FLEN  (FLEN)
      ) u_cls (
         .val_i (opnd[gi]),
         .cls_o (cls[gi])
      );
   end

   logic le_ab;
   logic le_ba;
   logic eq_ab;

   hcmp_order #(
      .EXP_W (EXP_W),
      .MAN_W (MAN_W),
      .FLEN  (FLEN)
   ) u_order (
      .a_i     (opnd[0]),
      .b_i     (opnd[1]),
      .cls_a_i (cls[0]),
      .cls_b_i (cls[1]),
      .le_ab_o (le_ab),
      .le_ba_o (le_ba),
      .eq_o    (eq_ab)
   );

   logic [FLEN-1:0] fp_d;
   logic            cmp_bit_d;
   logic            nv_d;

   hcmp_result #(
      .EXP_W (EXP_W),
      .MAN_W (MAN_W),
      .FLEN  (FLEN)
   ) u_result (
      .op_i    (op_sel),
      .a_i     (opnd[0]),
      .b_i     (opnd[1]),
      .cls_a_i (cls[0]),
      .cls_b_i (cls[1]),
      .le_ab_i (le_ab),
      .le_ba_i (le_ba),
      .eq_i    (eq_ab),
      .fp_o    (fp_d),
      .cmp_o   (cmp_bit_d),
      .nv_o    (nv_d)
   );

   logic [XLEN-1:0]   cmp_d;
   logic [FLAG_W-1:0] flags_d;

   always_comb begin
      cmp_d          = '0;
      cmp_d[0]       = cmp_bit_d;
      flags_d        = '0;
      flags_d[NV_POS] = nv_d;
   end

   if (OUT_STAGE == 1) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fp_res_o  <= '0;
            cmp_res_o <= '0;
            flags_o   <= '0;
         end else begin
            fp_res_o  <= fp_d;
            cmp_res_o <= cmp_d;
            flags_o   <= flags_d;
         end
      end
   end else begin : g_comb_out
      assign fp_res_o  = fp_d;
      assign cmp_res_o = cmp_d;
      assign flags_o   = flags_d;
   end

endmodule

// File: rtl/hcmp_unit_chk.sv
`timescale 1ns/1ps
module hcmp_unit_chk #(
   parameter int EXP_W     = 5,
   parameter int MAN_W     = 10,
   parameter int XLEN      = 32,
   parameter int FLAG_W    = 5,
   parameter int NV_POS    = 4,
   parameter int OUT_STAGE = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [2:0]           op_i,
   input logic [EXP_W+MAN_W:0] opa_i,
   input logic [EXP_W+MAN_W:0] opb_i,
   input logic [EXP_W+MAN_W:0] fp_res_o,
   input logic [XLEN-1:0]      cmp_res_o,
   input logic [FLAG_W-1:0]    flags_o
);

   localparam int FLEN = 1 + EXP_W + MAN_W;
   localparam logic [FLAG_W-1:0] NV_MASK = FLAG_W'(1) << NV_POS;
   localparam logic [FLEN-1:0] QNAN_REF =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   // Inputs aligned with the outputs they produced
   logic [2:0]      s_op;
   logic [FLEN-1:0] s_a;
   logic [FLEN-1:0] s_b;
   logic            s_v;

   if (OUT_STAGE == 1) begin : g_align_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_op <= '0;
            s_a  <= '0;
            s_b  <= '0;
            s_v  <= 1'b0;
         end else begin
            s_op <= op_i;
            s_a  <= opa_i;
            s_b  <= opb_i;
            s_v  <= 1'b1;
         end
      end
   end else begin : g_align_comb
      always_comb begin
         s_op = op_i;
         s_a  = opa_i;
         s_b  = opb_i;
         s_v  = 1'b1;
      end
   end

   logic a_nan, b_nan, a_snan, b_snan;
   assign a_nan  = (&s_a[FLEN-2:MAN_W]) && (s_a[MAN_W-1:0] != '0);
   assign b_nan  = (&s_b[FLEN-2:MAN_W]) && (s_b[MAN_W-1:0] != '0);
   assign a_snan = a_nan && !s_a[MAN_W-1];
   assign b_snan = b_nan && !s_b[MAN_W-1];

   assert_sgnj_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s_v && s_op == 3'd0) |-> (fp_res_o == {s_b[FLEN-1], s_a[FLEN-2:0]}));

   assert_sgnj_noflag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s_v && s_op <= 3'd2) |-> (flags_o == '0));

   assert_minmax_nan_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_v && (s_op == 3'd3 || s_op == 3'd4) && a_nan && b_nan) |-> (fp_res_o == QNAN_REF));

   assert_quiet_nv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_v && (s_op == 3'd3 || s_op == 3'd4 || s_op == 3'd5)) |->
         (flags_o[NV_POS] == (a_snan || b_snan)));

   assert_signal_nv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_v && (s_op == 3'd6 || s_op == 3'd7)) |-> (flags_o[NV_POS] == (a_nan || b_nan)));

   assert_nan_cmp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_v && s_op >= 3'd5 && (a_nan || b_nan)) |-> (cmp_res_o == '0));

   assert_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
      s_v |-> ((cmp_res_o >> 1) == '0 && (flags_o & ~NV_MASK) == '0 &&
               (s_op >= 3'd5 ? fp_res_o == '0 : cmp_res_o == '0)));

endmodule

bind hcmp_unit hcmp_unit_chk #(
   .EXP_W     (EXP_W),
   .MAN_W     (MAN_W),
   .XLEN      (XLEN),
   .FLAG_W    (FLAG_W),
   .NV_POS    (NV_POS),
   .OUT_STAGE (OUT_STAGE)
) u_hcmp_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_i      (op_i),
   .opa_i     (opa_i),
   .opb_i     (opb_i),
   .fp_res_o  (fp_res_o),
   .cmp_res_o (cmp_res_o),
   .flags_o   (flags_o)
);

// File: tb/test_hcmp_unit.sv
`timescale 1ns/1ps
module test_hcmp_unit;

   localparam int XLEN = 32;
   localparam int NVEC = 36;
   localparam int VW   = 61;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       op = 3'd7;
   logic [15:0]      a = 16'h3C00;
   logic [15:0]      b = 16'h3C00;
   logic [15:0]      fp_res;
   logic [XLEN-1:0]  cmp_res;
   logic [4:0]       flags;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   hcmp_unit i_hcmp_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .opa_i     (a),
      .opb_i     (b),
      .fp_res_o  (fp_res),
      .cmp_res_o (cmp_res),
      .flags_o   (flags)
   );

   // {req, op, a, b, expected fp, expected compare bit, expected flags}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {4'd1, 3'd0, 16'h3C00, 16'hC000, 16'hBC00, 1'b0, 5'h00},  // R1 copy sign
      {4'd1, 3'd1, 16'h3C00, 16'hC000, 16'h3C00, 1'b0, 5'h00},  // R1 inverted sign
      {4'd1, 3'd2, 16'hBC00, 16'hC000, 16'h3C00, 1'b0, 5'h00},  // R1 xor sign
      {4'd1, 3'd0, 16'h7C01, 16'h0000, 16'h7C01, 1'b0, 5'h00},  // R1 sNaN, no flag
      {4'd2, 3'd3, 16'h3C00, 16'h4000, 16'h3C00, 1'b0, 5'h00},  // R2 min positive
      {4'd2, 3'd4, 16'h3C00, 16'h4000, 16'h4000, 1'b0, 5'h00},  // R2 max positive
      {4'd2, 3'd3, 16'hBC00, 16'hC000, 16'hC000, 1'b0, 5'h00},  // R2 min negative
      {4'd2, 3'd4, 16'hBC00, 16'hC000, 16'hBC00, 1'b0, 5'h00},  // R2 max negative
      {4'd4, 3'd3, 16'h7E00, 16'h4000, 16'h4000, 1'b0, 5'h00},  // R4 one qNaN
      {4'd6, 3'd4, 16'h4000, 16'h7C01, 16'h4000, 1'b0, 5'h10},  // R6 sNaN in max
      {4'd4, 3'd3, 16'h7C01, 16'hFE00, 16'h7E00, 1'b0, 5'h10},  // R4 two NaNs
      {4'd4, 3'd4, 16'h7E00, 16'hFE00, 16'h7E00, 1'b0, 5'h00},  // R4 two qNaNs
      {4'd5, 3'd3, 16'h0000, 16'h8000, 16'h8000, 1'b0, 5'h00},  // R5 min +0,-0
      {4'd5, 3'd4, 16'h8000, 16'h0000, 16'h0000, 1'b0, 5'h00},  // R5 max -0,+0
      {4'd5, 3'd3, 16'h8000, 16'h0000, 16'h8000, 1'b0, 5'h00},  // R5 min -0,+0
      {4'd9, 3'd5, 16'h3C00, 16'h3C00, 16'h0000, 1'b1, 5'h00},  // R9 eq format
      {4'd3, 3'd5, 16'h0000, 16'h8000, 16'h0000, 1'b1, 5'h00},  // R3 +0 == -0
      {4'd8, 3'd5, 16'h7E00, 16'h7E00, 16'h0000, 1'b0, 5'h00},  // R8 qNaN eq quiet
      {4'd6, 3'd5, 16'h7C01, 16'h3C00, 16'h0000, 1'b0, 5'h10},  // R6 sNaN eq
      {4'd2, 3'd6, 16'h3C00, 16'h4000, 16'h0000, 1'b1, 5'h00},  // R2 lt true
      {4'd2, 3'd6, 16'h4000, 16'h3C00, 16'h0000, 1'b0, 5'h00},  // R2 lt false
      {4'd3, 3'd6, 16'h8000, 16'h0000, 16'h0000, 1'b0, 5'h00},  // R3 -0 < +0 false
      {4'd3, 3'd7, 16'h8000, 16'h0000, 16'h0000, 1'b1, 5'h00},  // R3 -0 <= +0
      {4'd3, 3'd7, 16'h0000, 16'h8000, 16'h0000, 1'b1, 5'h00},  // R3 +0 <= -0
      {4'd3, 3'd7, 16'h3C00, 16'hBC00, 16'h0000, 1'b0, 5'h00},  // R3 pos vs neg
      {4'd3, 3'd7, 16'hBC00, 16'h3C00, 16'h0000, 1'b1, 5'h00},  // R3 neg vs pos
      {4'd2, 3'd7, 16'hC000, 16'hBC00, 16'h0000, 1'b1, 5'h00},  // R2 -2 <= -1
      {4'd2, 3'd7, 16'hBC00, 16'hC000, 16'h0000, 1'b0, 5'h00},  // R2 -1 <= -2
      {4'd2, 3'd7, 16'h3E00, 16'h3C00, 16'h0000, 1'b0, 5'h00},  // R2 mantissa order
      {4'd2, 3'd7, 16'h3C00, 16'h3E00, 16'h0000, 1'b1, 5'h00},  // R2 mantissa order
      {4'd7, 3'd6, 16'h7E00, 16'h3C00, 16'h0000, 1'b0, 5'h10},  // R7 qNaN lt
      {4'd7, 3'd7, 16'h3C00, 16'hFE00, 16'h0000, 1'b0, 5'h10},  // R7 qNaN le
      {4'd2, 3'd7, 16'h7C00, 16'h7C00, 16'h0000, 1'b1, 5'h00},  // R2 inf <= inf
      {4'd3, 3'd6, 16'hFC00, 16'h0001, 16'h0000, 1'b1, 5'h00},  // R3 -inf < subnormal
      {4'd2, 3'd7, 16'h0001, 16'h0000, 16'h0000, 1'b0, 5'h00},  // R2 subnormal <= 0
      {4'd2, 3'd6, 16'hBC00, 16'hBC00, 16'h0000, 1'b0, 5'h00}   // R2 lt equal values
   };

   task automatic check_out(input int req, input string what,
                            input logic [15:0] e_fp, input logic e_cmp,
                            input logic [4:0] e_fl);
      logic [XLEN-1:0] e_cmp_w;
      e_cmp_w = {{(XLEN-1){1'b0}}, e_cmp};
      checks++;
      if (fp_res !== e_fp || cmp_res !== e_cmp_w || flags !== e_fl) begin
         errors++;
         $display("FAIL R%0d %s: fp %h exp %h, cmp %h exp %h, flags %h exp %h",
                  req, what, fp_res, e_fp, cmp_res, e_cmp_w, flags, e_fl);
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      // R10: outputs stay zero under reset with non-zero inputs applied
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_out(10, "reset holds outputs at zero", 16'h0000, 1'b0, 5'h00);
      rst_n = 1'b1;

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         op = VEC[i][56:54];
         a  = VEC[i][53:38];
         b  = VEC[i][37:22];
         @(posedge clk);
         #1;
         check_out(int'(VEC[i][60:57]), $sformatf("vector %0d", i),
                   VEC[i][21:6], VEC[i][5], VEC[i][4:0]);
      end

      // R10: result appears only after the next rising edge
      @(negedge clk);
      op = 3'd5; a = 16'h3C00; b = 16'h4000;
      @(posedge clk);
      @(negedge clk);
      b = 16'h3C00;
      #1;
      check_out(10, "old result held before edge", 16'h0000, 1'b0, 5'h00);
      @(posedge clk);
      #1;
      check_out(10, "new result after edge", 16'h0000, 1'b1, 5'h00);

      // R9: sign-inject leaves the compare output zero
      @(negedge clk);
      op = 3'd2; a = 16'h7E00; b = 16'hFC00;
      @(posedge clk);
      #1;
      check_out(9, "sgnjx format", 16'hFE00, 1'b0, 5'h00);

      // R10: asynchronous reset clears outputs at once
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_out(10, "async reset clears", 16'h0000, 1'b0, 5'h00);
      @(negedge clk);
      rst_n = 1'b1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule